// File: doc/BRIEF.md
# RGB breathing colour sequencer

This block produces the three duty-width values for one RGB LED and hands them, together with a fixed period value, to a per-channel PWM generator that sits outside it. Each colour has its own triangle fade: its duty value climbs by one step to a ceiling, then falls back to zero. The step rates differ per colour, so each colour has its own update timer. All three timers count a shared millisecond strobe that comes from a clock prescaler.

A four-state machine decides which colours may step. The states are `MODE_RED`, `MODE_GRN`, `MODE_BLU` and `MODE_ALL`. The named transitions are:

- `ADV_RED` (`MODE_RED` to `MODE_GRN`): the red fade returns to zero.
- `ADV_GRN` (`MODE_GRN` to `MODE_BLU`): the green fade returns to zero.
- `ADV_BLU` (`MODE_BLU` to `MODE_ALL`): the blue fade returns to zero.
- `WRAP` (`MODE_ALL` to `MODE_RED`): the blue fade returns to zero while the repeat counter is zero. `WRAP` clears every fade.
- `REPEAT`: the machine stays in `MODE_ALL` and decrements the repeat counter.

Timing intervals, the fade ceiling and the repeat count are parameters, so two instances can run at different speeds. For example, a second instance can use half of each interval and a repeat count of 5.

Top module: `rgb_fade_seq`

## Requirements
- R1: `period_o` always equals the parameter `PERIOD` (default 0x80).
- R2: While `rst_n` is low and after its release, the block behaves as follows until the first update:
  - the mode is `MODE_RED`;
  - all duties and all three width outputs are 0;
  - all fades ascend;
  - the repeat counter holds `REPEAT_INIT`.
- R3: A one-cycle millisecond strobe fires once every `CLKS_PER_MS` enabled clocks. Each colour's timer fires on every `RED_MS`, `GRN_MS` or `BLU_MS`-th strobe. The defaults are 50, 40 and 30. The first firing comes on that strobe count after reset.
- R4: A granted update does two things in one clock edge:
  - it copies the colour's current duty to its width output;
  - it steps the duty.
  While ascending, the step adds 1 and the fade turns to descending when the new duty equals `CEIL` (default 0x30). While descending, the step subtracts 1 and the fade turns to ascending when the new duty is 0.
- R5: The mode order is `MODE_RED`, `MODE_GRN`, `MODE_BLU`, `MODE_ALL`, then `MODE_RED`.
- R6: In a single-colour mode, timer firings of the other two colours are ignored. Their width outputs keep their values.
- R7: A single-colour mode advances when its own colour's descending step reaches 0.
- R8: In `MODE_ALL` all three colours update on their own firings. Only a blue step to 0 counts towards leaving the mode: if the repeat counter is 0 the mode wraps, otherwise the counter decrements by one and the mode stays.
- R9: On `WRAP` the block does all of the following in the same edge, and this overrides any update in that edge:
  - all width outputs and duties become 0;
  - all fades ascend;
  - the repeat counter reloads `REPEAT_INIT`.
- R10: Firings that fall in the same cycle are all processed in that cycle. The mode decision is taken after all three updates.
- R11: While `en` is low, the prescaler and the timers hold and no width output changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| en | input | 1 | run enable; low freezes the time base |
| width_r_o | output | 8 | red duty width |
| width_g_o | output | 8 | green duty width |
| width_b_o | output | 8 | blue duty width |
| period_o | output | 8 | constant PWM period |

## Verification
Two things can fall in the same cycle:
- firings of two or three colour timers;
- a blue return to zero that wraps the mode, together with another colour's firing.

The bench uses intervals of 5, 4 and 3 ms, which collide every 12, 15 and 20 ms. It runs through two full mode loops, so both cases occur. A behavioural model processes the firings of a cycle in red, green, blue order and applies the clear last. The width outputs are compared with this model on every clock, and each comparison in such a cycle is tagged R10 or R9.

// File: rtl/rgbseq_pkg.sv
package rgbseq_pkg;
    typedef enum logic [1:0] {
        MODE_RED = 2'd0,
        MODE_GRN = 2'd1,
        MODE_BLU = 2'd2,
        MODE_ALL = 2'd3
    } mode_e;

    localparam int NCH  = 3;
    localparam int CH_R = 0;
    localparam int CH_G = 1;
    localparam int CH_B = 2;
endpackage

// File: rtl/rgbseq_tick.sv
module rgbseq_tick #(
    parameter int CLKS_PER_MS = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic ms_o
);
    localparam int CW = (CLKS_PER_MS > 1) ? $clog2(CLKS_PER_MS) : 1;

    logic [CW-1:0] cnt_q;
    logic          last;

    assign last = (cnt_q == CW'(CLKS_PER_MS - 1));
    assign ms_o = en && last;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (en) begin
            cnt_q <= last ? '0 : cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/rgbseq_timer.sv
module rgbseq_timer #(
    parameter int INTERVAL_MS = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ms_i,
    output logic fire_o
);
    localparam int TW = (INTERVAL_MS > 1) ? $clog2(INTERVAL_MS) : 1;
    localparam logic [TW-1:0] RELOAD = TW'(INTERVAL_MS - 1);

    logic [TW-1:0] cnt_q;

    assign fire_o = ms_i && (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= RELOAD;
        end else if (ms_i) begin
            cnt_q <= (cnt_q == '0) ? RELOAD : cnt_q - 1'b1;
        end
    end
endmodule

// File: rtl/rgbseq_fade.sv
module rgbseq_fade #(
    parameter int CEIL = 48,
    parameter int DW   = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          upd_i,
    input  logic          clr_i,
    output logic [DW-1:0] width_o,
    output logic          zero_o
);
    logic [DW-1:0] duty_q;
    logic          up_q;

    // a descending step from 1 lands on zero this edge
    assign zero_o = upd_i && !up_q && (duty_q == DW'(1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            width_o <= '0;
            duty_q  <= '0;
            up_q    <= 1'b1;
        end else if (clr_i) begin
            width_o <= '0;
            duty_q  <= '0;
            up_q    <= 1'b1;
        end else if (upd_i) begin
            width_o <= duty_q;
            if (up_q) begin
                duty_q <= duty_q + 1'b1;
                if (duty_q + 1'b1 == DW'(CEIL)) up_q <= 1'b0;
            end else begin
                duty_q <= duty_q - 1'b1;
                if (duty_q == DW'(1)) up_q <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/rgb_fade_seq.sv
module rgb_fade_seq
    import rgbseq_pkg::*;
#(
    parameter int CLKS_PER_MS = 1000,
    parameter int RED_MS      = 50,
    parameter int GRN_MS      = 40,
    parameter int BLU_MS      = 30,
    parameter int CEIL        = 48,
    parameter int PERIOD      = 128,
    parameter int REPEAT_INIT = 10,
    parameter int DW          = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    output logic [DW-1:0] width_r_o,
    output logic [DW-1:0] width_g_o,
    output logic [DW-1:0] width_b_o,
    output logic [DW-1:0] period_o
);
    localparam int RW = (REPEAT_INIT > 0) ? $clog2(REPEAT_INIT + 1) : 1;
    localparam int IVL [NCH] = '{RED_MS, GRN_MS, BLU_MS};

    logic           ms;
    logic [NCH-1:0] fire;
    logic [NCH-1:0] grant;
    logic [NCH-1:0] zero;
    logic [DW-1:0]  width [NCH];

    mode_e          mode_q, mode_d;
    logic [RW-1:0]  rep_q, rep_d;
    logic           advance;
    logic           wrap;

    rgbseq_tick #(.CLKS_PER_MS(CLKS_PER_MS)) u_tick (
        .clk(clk), .rst_n(rst_n), .en(en), .ms_o(ms)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        rgbseq_timer #(.INTERVAL_MS(IVL[c])) u_tmr (
            .clk(clk), .rst_n(rst_n), .ms_i(ms), .fire_o(fire[c])
        );
        rgbseq_fade #(.CEIL(CEIL), .DW(DW)) u_fade (
            .clk(clk), .rst_n(rst_n), .upd_i(grant[c]), .clr_i(wrap),
            .width_o(width[c]), .zero_o(zero[c])
        );
    end

    // next-state and grant decision (after all channel events of the cycle)
    always_comb begin
        grant   = '0;
        advance = 1'b0;
        unique case (mode_q)
            MODE_RED: begin grant[CH_R] = fire[CH_R]; advance = zero[CH_R]; end // ADV_RED
            MODE_GRN: begin grant[CH_G] = fire[CH_G]; advance = zero[CH_G]; end // ADV_GRN
            MODE_BLU: begin grant[CH_B] = fire[CH_B]; advance = zero[CH_B]; end // ADV_BLU
            MODE_ALL: begin grant = fire; advance = zero[CH_B] && (rep_q == '0); end // WRAP
        endcase
        wrap   = advance && (mode_q == MODE_ALL);
        mode_d = advance ? mode_e'(mode_q + 2'd1) : mode_q;
        rep_d  = rep_q;
        if (wrap)
            rep_d = RW'(REPEAT_INIT);
        else if (mode_q == MODE_ALL && zero[CH_B])
            rep_d = rep_q - 1'b1;                                  // REPEAT
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= MODE_RED;
            rep_q  <= RW'(REPEAT_INIT);
        end else begin
            mode_q <= mode_d;
            rep_q  <= rep_d;
        end
    end

    // outputs
    always_comb begin
        width_r_o = width[CH_R];
        width_g_o = width[CH_G];
        width_b_o = width[CH_B];
        period_o  = DW'(PERIOD);
    end
endmodule

// File: rtl/rgbseq_chk.sv
module rgbseq_chk #(
    parameter int CEIL = 48,
    parameter int RW   = 4,
    parameter int DW   = 8,
    parameter int REPEAT_INIT = 10
) (
    input logic          clk,
    input logic          rst_n,
    input logic          en,
    input logic [1:0]    mode_i,
    input logic [RW-1:0] rep_i,
    input logic [DW-1:0] wr_i,
    input logic [DW-1:0] wg_i,
    input logic [DW-1:0] wb_i
);
    // R5: any mode change goes to the next mode in order
    a_r5_mode_order: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i != $past(mode_i)) |-> (mode_i == 2'($past(mode_i) + 2'd1)));

    // R6: red-only mode leaves green and blue untouched
    a_r6_others_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == 2'd0) |=> ($stable(wg_i) && $stable(wb_i)));

    // R8: repeat counter only ever drops by one while in all-colours mode
    a_r8_repeat_step: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mode_i) == 2'd3 && mode_i == 2'd3 && rep_i != $past(rep_i))
        |-> (rep_i == $past(rep_i) - 1'b1));

    // R9: wrap clears widths and reloads the repeat count
    a_r9_wrap_clear: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mode_i) == 2'd3 && mode_i == 2'd0)
        |-> (wr_i == '0 && wg_i == '0 && wb_i == '0 && rep_i == RW'(REPEAT_INIT)));

    // R11: enable low freezes every width
    a_r11_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> ($stable(wr_i) && $stable(wg_i) && $stable(wb_i)));

    // R4: widths never exceed the ceiling
    a_r4_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i <= DW'(CEIL)) && (wg_i <= DW'(CEIL)) && (wb_i <= DW'(CEIL)));
endmodule

bind rgb_fade_seq rgbseq_chk #(.CEIL(CEIL), .RW(RW), .DW(DW), .REPEAT_INIT(REPEAT_INIT)) u_chk (
    .clk(clk), .rst_n(rst_n), .en(en), .mode_i(mode_q), .rep_i(rep_q),
    .wr_i(width_r_o), .wg_i(width_g_o), .wb_i(width_b_o)
);

// File: tb/sim_rgb_fade_seq.sv
module sim_rgb_fade_seq;
    localparam int CLK_PERIOD = 10;
    localparam int P    = 3;
    localparam int IV_R = 5, IV_G = 4, IV_B = 3;
    localparam int CEILV = 6;
    localparam int REP   = 3;
    localparam int PER   = 128;
    localparam int MAXCYC = 20000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b1;
    logic [7:0] wr, wg, wb, per;

    always #(CLK_PERIOD/2) clk = ~clk;

    rgb_fade_seq #(.CLKS_PER_MS(P), .RED_MS(IV_R), .GRN_MS(IV_G), .BLU_MS(IV_B),
                   .CEIL(CEILV), .PERIOD(PER), .REPEAT_INIT(REP), .DW(8)) u0 (
        .clk(clk), .rst_n(rst_n), .en(en),
        .width_r_o(wr), .width_g_o(wg), .width_b_o(wb), .period_o(per)
    );

    int checks = 0;
    int errors = 0;

    // behavioural reference state
    int pc;
    int tc [3];
    int duty [3];
    bit up [3];
    int wexp [3];
    int mode;
    int rep;
    int wraps;
    bit fresh;
    string tag = "R2";
    bit comparing = 1'b0;

    function automatic int ivl(int c);
        return (c == 0) ? IV_R : (c == 1) ? IV_G : IV_B;
    endfunction

    task automatic model_reset();
        pc = 0; mode = 0; rep = REP; fresh = 0;
        for (int c = 0; c < 3; c++) begin
            tc[c] = ivl(c) - 1; duty[c] = 0; up[c] = 1; wexp[c] = 0;
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            model_reset();
            tag = "R2";
        end else begin
            bit strobe;
            bit fire [3];
            bit grant [3];
            bit zero_b, zero_own, adv;
            int ngrant, nfire;
            string t;
            strobe = en && (pc == P - 1);
            if (en) pc = strobe ? 0 : pc + 1;
            nfire = 0; ngrant = 0; zero_b = 0; zero_own = 0;
            for (int c = 0; c < 3; c++) begin
                fire[c] = strobe && (tc[c] == 0);
                if (strobe) tc[c] = (tc[c] == 0) ? ivl(c) - 1 : tc[c] - 1;
                grant[c] = fire[c] && (mode == 3 || mode == c);
                if (fire[c]) nfire++;
            end
            // process in red, green, blue order
            for (int c = 0; c < 3; c++) begin
                if (grant[c]) begin
                    ngrant++;
                    wexp[c] = duty[c];
                    if (up[c]) begin
                        duty[c]++;
                        if (duty[c] == CEILV) up[c] = 0;
                    end else begin
                        duty[c]--;
                        if (duty[c] == 0) begin
                            up[c] = 1;
                            if (c == 2) zero_b = 1;
                            if (c == mode) zero_own = 1;
                        end
                    end
                end
            end
            t = (nfire > ngrant) ? "R6" : (ngrant > 0 ? "R4" : "R3");
            if (ngrant > 0 && fresh) begin t = "R5"; fresh = 0; end
            if (ngrant > 1) t = "R10";
            adv = 0;
            if (mode == 3) begin
                if (zero_b) begin
                    if (rep == 0) adv = 1;
                    else begin rep--; t = "R8"; end
                end
            end else if (zero_own) begin
                adv = 1; t = "R7";
            end
            if (adv) begin
                fresh = 1;
                if (mode == 3) begin
                    mode = 0; rep = REP; wraps++; t = "R9";
                    for (int c = 0; c < 3; c++) begin
                        duty[c] = 0; up[c] = 1; wexp[c] = 0;
                    end
                end else mode++;
            end
            if (!en) t = "R11";
            tag = t;
        end
    end

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (comparing) begin
            check({tag, " red"},   int'(wr), wexp[0]);
            check({tag, " green"}, int'(wg), wexp[1]);
            check({tag, " blue"},  int'(wb), wexp[2]);
            check("R1 period", int'(per), PER);
        end
    end

    initial begin
        int cyc;
        wraps = 0;
        repeat (4) @(negedge clk);
        check("R2 reset red",   int'(wr), 0);
        check("R2 reset green", int'(wg), 0);
        check("R2 reset blue",  int'(wb), 0);
        check("R1 period in reset", int'(per), PER);
        rst_n = 1'b1;
        comparing = 1'b1;
        cyc = 0;
        while (wraps < 2 && cyc < MAXCYC) begin
            @(negedge clk);
            cyc++;
            if (cyc == 400) en = 1'b0;     // R11 freeze window
            if (cyc == 460) en = 1'b1;
            if (cyc == 1500) en = 1'b0;
            if (cyc == 1517) en = 1'b1;
        end
        repeat (20) @(negedge clk);
        comparing = 1'b0;
        checks++;
        if (wraps < 2) begin
            errors++;
            $display("FAIL watchdog R9: actual %0d wraps expected 2", wraps);
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule